// File: doc/BRIEF.md
# Cascade-Gated Countdown Timer

This block is a down-counting timer with a programmable reload value. Software loads a reload value and a starting count through a small synchronous register port, then sets the enable bit. On every clock where the timer is running, the count drops by one. When the count is zero on a running clock, it is reloaded instead of decremented. Writing a reload value of N therefore gives a period of N+1 clocks, for example N = f_clk / f_tick − 1. Each zero-reach can raise a one-cycle interrupt pulse and sets a sticky status flag. Two mode bits choose what happens at zero: the timer keeps running, only its active bit is dropped, or both enable and active are dropped.

Counting can be qualified by three cascade signals. Each one is picked by its own selector from a wide event vector and passes through a two-flop synchronizer. Two start cascades can each be enabled, inverted and set to trigger mode. In trigger mode a rising edge arms counting, and the input is then ignored until the timer goes inactive. When both start cascades are enabled, they are combined by AND or by OR. The third cascade is a stop source. In level mode it halts the timer whenever it is asserted. In trigger mode it disables the timer only if it is asserted at the moment the count reaches zero.

Top module: `cascade_timer`

## Requirements
- R1: After reset the count is 0, enable and active are 0, the interrupt output is low and every register reads 0.
- R2: Register map, all written on a clock where `reg_we` is 1:
  - Address 1 is the reload value.
  - On a running clock, a zero count is replaced by the reload value; any other count drops by one.
  - A period is therefore reload+1 clocks, and the reload value reads back at address 1.
- R3: Control word at address 0:
  - bit0 enable, bit1 interrupt enable, bit2 auto-disable, bit3 auto-deactivate.
  - A read also returns the active bit in bit4.
  - Writing the word with bit0 = 1 sets both enable and active; writing it with bit0 = 0 clears both.
  - With auto-disable set, a zero-reach clears both enable and active.
- R4: With auto-deactivate set and auto-disable clear, a zero-reach clears only active. Enable stays 1 and counting halts. With both bits set, auto-disable governs.
- R5: With neither mode bit set, the timer keeps running through zero-reaches, with enable and active staying 1.
- R6: Cascade control word at address 3:
  - bit0 start cascade 0 enable, bit1 its invert; bit2 start cascade 1 enable, bit3 its invert.
  - An enabled start cascade must be asserted (after optional inversion) for counting to proceed.
  - A disabled start cascade imposes no condition.
- R7: With both start cascades enabled, bit4 of the cascade control word selects AND (0) or OR (1) of the two conditions.
- R8: Trigger mode is bit5 for cascade 0 and bit6 for cascade 1. In trigger mode, a rising edge of the synchronized, post-inversion cascade arms counting while the timer is enabled and active. From then on the cascade level is ignored until the timer is deactivated, disabled or its control word is rewritten.
- R9: The stop cascade is enabled by bit7 of the cascade control word and inverted by bit8. With bit9 clear, an asserted stop cascade clears enable and active.
- R10: With bit9 set, an asserted stop cascade is ignored at nonzero counts. It clears enable and active when a zero-reach occurs while it is asserted.
- R11: A write to address 2 loads the count at that clock edge, taking priority over counting. When enabled, counting then continues down from the new value.
- R12: Interrupt and status:
  - Each zero-reach produces a one-cycle pulse on `irq_o` in the next cycle, if interrupt enable is set.
  - Each zero-reach also sets the status flag, bit0 at address 7, whatever the interrupt enable.
  - Writing 1 to that bit clears it.
- R13: Addresses 4, 5 and 6 hold the event index of start cascade 0, start cascade 1 and the stop cascade. Any index of the event vector can be selected, including high indexes such as 112. Cascade inputs act two clocks after they change, through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for writes and reads |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` (combinational) |
| evt_i | input | EVT_W | Event vector the cascades select from |
| count_o | output | CNT_W | Current count |
| enable_o | output | 1 | Enable bit |
| active_o | output | 1 | Active bit |
| irq_o | output | 1 | One-cycle terminal-count interrupt |

## Verification
A table of reload values is walked, and each entry is paired with one of the four mode-bit settings. This separates the period length from the state the timer is left in after a zero-reach: running, deactivated or disabled. The cascade patterns follow:

- A start cascade low and then high shows gating. The same input inverted shows the polarity.
- One start cascade high and the other low tells AND from OR.
- A short pulse that drops while counting continues tells trigger mode from level mode.
- A stop cascade held high during a nonzero count, and then at zero, tells level stop from stop-at-zero.

Count writes while running, interrupt-disabled zero-reaches with status read-back, and clearing the status flag cover the register-side behaviour.

// File: rtl/casc_tmr_pkg.sv
package casc_tmr_pkg;

    // cascade control word, bit0 at the bottom
    typedef struct packed {
        logic stop_trg;   // bit9
        logic stop_inv;   // bit8
        logic stop_en;    // bit7
        logic trg1;       // bit6
        logic trg0;       // bit5
        logic dual_or;    // bit4
        logic inv1;       // bit3
        logic en1;        // bit2
        logic inv0;       // bit1
        logic en0;        // bit0
    } csd_cfg_t;

    // mode flags held apart from the enable state
    typedef struct packed {
        logic auto_deact;
        logic auto_dis;
        logic irq_en;
    } tmr_mode_t;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_RELOAD = 3'd1,
        A_COUNT  = 3'd2,
        A_CSD    = 3'd3,
        A_SEL0   = 3'd4,
        A_SEL1   = 3'd5,
        A_SEL2   = 3'd6,
        A_STAT   = 3'd7
    } reg_addr_e;

    localparam int NUM_CSD = 3;

    // combine two start terms according to their enables and the dual op
    function automatic logic combine_start(input logic e0, input logic t0,
                                           input logic e1, input logic t1,
                                           input logic use_or);
        logic r;
        if (e0 && e1)   r = use_or ? (t0 | t1) : (t0 & t1);
        else if (e0)    r = t0;
        else if (e1)    r = t1;
        else            r = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/csd_select.sv
module csd_select #(
    parameter int EVT_W = 128,
    localparam int SEL_W = $clog2(EVT_W)
) (
    input  logic [EVT_W-1:0] evt,
    input  logic [SEL_W-1:0] sel,
    output logic             y
);
    assign y = evt[sel];
endmodule

// File: rtl/csd_sync.sv
module csd_sync (
    input  logic clk,
    input  logic rst,
    input  logic d,
    input  logic inv,
    output logic lvl
);
    logic s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign lvl = s2 ^ inv;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import casc_tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SEL_W = 7
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [2:0]                    addr,
    input  logic [CNT_W-1:0]              wdata,
    output logic [CNT_W-1:0]              rdata,
    input  logic [CNT_W-1:0]              cnt_i,
    input  logic                          en_i,
    input  logic                          act_i,
    input  logic                          stat_i,
    output logic [CNT_W-1:0]              reload_o,
    output tmr_mode_t                     mode_o,
    output csd_cfg_t                      csd_o,
    output logic [NUM_CSD-1:0][SEL_W-1:0] sel_o,
    output logic                          wr_ctrl_o,
    output logic                          wr_en_o,
    output logic                          wr_cnt_o,
    output logic                          clr_stat_o
);
    reg_addr_e a;
    assign a = reg_addr_e'(addr);

    assign wr_ctrl_o  = we && (a == A_CTRL);
    assign wr_en_o    = wdata[0];
    assign wr_cnt_o   = we && (a == A_COUNT);
    assign clr_stat_o = we && (a == A_STAT) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_o <= '0;
            mode_o   <= '0;
            csd_o    <= '0;
            sel_o    <= '0;
        end else if (we) begin
            case (a)
                A_CTRL:   mode_o   <= tmr_mode_t'(wdata[3:1]);
                A_RELOAD: reload_o <= wdata;
                A_CSD:    csd_o    <= csd_cfg_t'(wdata[9:0]);
                A_SEL0:   sel_o[0] <= wdata[SEL_W-1:0];
                A_SEL1:   sel_o[1] <= wdata[SEL_W-1:0];
                A_SEL2:   sel_o[2] <= wdata[SEL_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (a)
            A_CTRL:   rdata[4:0] = {act_i, mode_o, en_i};
            A_RELOAD: rdata = reload_o;
            A_COUNT:  rdata = cnt_i;
            A_CSD:    rdata[9:0] = csd_o;
            A_SEL0:   rdata[SEL_W-1:0] = sel_o[0];
            A_SEL1:   rdata[SEL_W-1:0] = sel_o[1];
            A_SEL2:   rdata[SEL_W-1:0] = sel_o[2];
            A_STAT:   rdata[0] = stat_i;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import casc_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  tmr_mode_t          mode,
    input  csd_cfg_t           csd,
    input  logic [NUM_CSD-1:0] lvl,
    input  logic [CNT_W-1:0]   reload,
    input  logic               wr_ctrl,
    input  logic               wr_en,
    input  logic               wr_cnt,
    input  logic [CNT_W-1:0]   wr_cnt_val,
    input  logic               clr_stat,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               en_q,
    output logic               act_q,
    output logic               irq_q,
    output logic               stat_q
);
    logic [1:0] lvl_d, lat;
    logic [1:0] rise;
    logic t0, t1, gate, run, at_zero, zev, stop_lvl, stop_zero;

    assign rise      = lvl[1:0] & ~lvl_d;
    assign t0        = csd.trg0 ? lat[0] : lvl[0];
    assign t1        = csd.trg1 ? lat[1] : lvl[1];
    assign gate      = combine_start(csd.en0, t0, csd.en1, t1, csd.dual_or);
    assign run       = en_q && act_q && gate;
    assign at_zero   = (cnt_q == '0);
    assign zev       = run && at_zero;
    assign stop_lvl  = csd.stop_en && !csd.stop_trg && lvl[2];
    assign stop_zero = csd.stop_en && csd.stop_trg && lvl[2] && zev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            en_q   <= 1'b0;
            act_q  <= 1'b0;
            irq_q  <= 1'b0;
            stat_q <= 1'b0;
            lvl_d  <= '0;
            lat    <= '0;
        end else begin
            if (wr_cnt)      cnt_q <= wr_cnt_val;
            else if (run)    cnt_q <= at_zero ? reload : cnt_q - CNT_W'(1);

            if (wr_ctrl) begin
                en_q  <= wr_en;
                act_q <= wr_en;
            end else if (stop_lvl || (zev && (mode.auto_dis || stop_zero))) begin
                en_q  <= 1'b0;
                act_q <= 1'b0;
            end else if (zev && mode.auto_deact) begin
                act_q <= 1'b0;
            end

            lvl_d <= lvl[1:0];
            for (int i = 0; i < 2; i++) begin
                if (wr_ctrl || !en_q || !act_q) lat[i] <= 1'b0;
                else if (rise[i])               lat[i] <= 1'b1;
            end

            irq_q <= zev && mode.irq_en;

            if (zev)           stat_q <= 1'b1;
            else if (clr_stat) stat_q <= 1'b0;
        end
    end

    // R3
    act_implies_en_chk: assert property (@(posedge clk) disable iff (rst)
        act_q |-> en_q);

    // R12
    irq_sets_stat_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> stat_q);

    // R12
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ($past(cnt_q) == '0));

    // R9
    stop_level_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_lvl && !wr_ctrl) |=> (!en_q && !act_q));

    // R2
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !at_zero && !wr_cnt) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
    import casc_tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int EVT_W = 128,
    localparam int SEL_W = $clog2(EVT_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic [EVT_W-1:0] evt_i,
    output logic [CNT_W-1:0] count_o,
    output logic             enable_o,
    output logic             active_o,
    output logic             irq_o
);
    logic [CNT_W-1:0]              reload, cnt;
    tmr_mode_t                     mode;
    csd_cfg_t                      csd;
    logic [NUM_CSD-1:0][SEL_W-1:0] sel;
    logic [NUM_CSD-1:0]            raw, lvl, inv;
    logic wr_ctrl, wr_en, wr_cnt, clr_stat, en, act, stat;

    assign inv = {csd.stop_inv, csd.inv1, csd.inv0};

    tmr_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .cnt_i(cnt), .en_i(en), .act_i(act), .stat_i(stat),
        .reload_o(reload), .mode_o(mode), .csd_o(csd), .sel_o(sel),
        .wr_ctrl_o(wr_ctrl), .wr_en_o(wr_en), .wr_cnt_o(wr_cnt),
        .clr_stat_o(clr_stat)
    );

    for (genvar g = 0; g < NUM_CSD; g++) begin : g_csd
        csd_select #(.EVT_W(EVT_W)) u_sel (
            .evt(evt_i), .sel(sel[g]), .y(raw[g])
        );
        csd_sync u_sync (
            .clk(clk), .rst(rst), .d(raw[g]), .inv(inv[g]), .lvl(lvl[g])
        );
    end

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .mode(mode), .csd(csd), .lvl(lvl),
        .reload(reload), .wr_ctrl(wr_ctrl), .wr_en(wr_en), .wr_cnt(wr_cnt),
        .wr_cnt_val(reg_wdata), .clr_stat(clr_stat), .cnt_q(cnt),
        .en_q(en), .act_q(act), .irq_q(irq_o), .stat_q(stat)
    );

    assign count_o  = cnt;
    assign enable_o = en;
    assign active_o = act;
endmodule

// File: tb/cascade_timer_bench.sv
module cascade_timer_bench;
    localparam int CW = 32;
    localparam int EW = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;
    logic [EW-1:0] evt = '0;
    logic [CW-1:0] count_o;
    logic enable_o, active_o, irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    cascade_timer #(.CNT_W(CW), .EVT_W(EW)) u_cascade_timer (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt),
        .count_o(count_o), .enable_o(enable_o), .active_o(active_o),
        .irq_o(irq_o)
    );

    // reload[19:4], mode {auto_dis, auto_deact}[3:2], exp enable[1], exp active[0]
    localparam logic [19:0] VEC [6] = '{
        {16'd3,  2'b00, 1'b1, 1'b1},
        {16'd0,  2'b00, 1'b1, 1'b1},
        {16'd7,  2'b10, 1'b0, 1'b0},
        {16'd5,  2'b01, 1'b1, 1'b0},
        {16'd9,  2'b11, 1'b0, 1'b0},
        {16'd20, 2'b00, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [CW-1:0] v;
        int k, hits;
        tick(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 enable", {31'd0, enable_o}, 0);
        chk("R1 active", {31'd0, active_o}, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);
        rd(3'd0, v); chk("R1 ctrl read", v, 0);

        // R2 R3 R4 R5 table walk
        foreach (VEC[i]) begin
            logic [15:0] n;
            logic [1:0] m;
            n = VEC[i][19:4];
            m = VEC[i][3:2];
            wr(3'd0, 0);
            wr(3'd3, 0);
            wr(3'd1, {16'd0, n});
            wr(3'd2, {16'd0, n});
            wr(3'd0, {28'd0, m[0], m[1], 2'b11});
            k = 0;
            do begin
                tick(1);
                k++;
            end while (!irq_o && k < 1000);
            chk("R2 period", k, n + 1);
            chk("R2 reload after zero", count_o, {16'd0, n});
            chk("R3 R4 R5 enable after zero", {31'd0, enable_o}, {31'd0, VEC[i][1]});
            chk("R3 R4 R5 active after zero", {31'd0, active_o}, {31'd0, VEC[i][0]});
            if (!VEC[i][0]) begin
                tick(1);
                chk("R12 single pulse", {31'd0, irq_o}, 0);
            end
        end
        rd(3'd1, v); chk("R2 reload readback", v, 20);

        // R6 gating by start cascade 0 on event 5
        wr(3'd0, 0);
        wr(3'd4, 5);
        wr(3'd3, 32'h1);
        wr(3'd1, 1000);
        wr(3'd2, 500);
        wr(3'd0, 1);
        tick(10);
        chk("R6 held while cascade low", count_o, 500);
        evt[5] = 1'b1;
        tick(10);
        chk("R6 counts two clocks after cascade rises", count_o, 492);
        wr(3'd0, 0);
        evt[5] = 1'b0;
        tick(5);
        wr(3'd3, 32'h3);
        wr(3'd2, 500);
        wr(3'd0, 1);
        tick(10);
        chk("R6 inverted cascade counts when low", count_o, 490);

        // R7 R13 dual operation with cascade 1 on event 112
        wr(3'd0, 0);
        wr(3'd5, 112);
        evt[5] = 1'b1;
        evt[112] = 1'b0;
        tick(5);
        wr(3'd3, 32'h5);
        wr(3'd2, 300);
        wr(3'd0, 1);
        tick(10);
        chk("R7 AND holds with one input low", count_o, 300);
        wr(3'd3, 32'h15);
        tick(10);
        chk("R7 OR counts with one input high", count_o, 290);
        evt[112] = 1'b1;
        tick(5);
        wr(3'd3, 32'h5);
        v = count_o;
        tick(4);
        chk("R13 AND counts with index 112 high", count_o, v - 4);

        // R8 trigger mode on cascade 0
        wr(3'd0, 0);
        evt[5] = 1'b0;
        tick(5);
        wr(3'd3, 32'h21);
        wr(3'd2, 400);
        wr(3'd0, 1);
        tick(10);
        chk("R8 armed but not triggered", count_o, 400);
        evt[5] = 1'b1;
        tick(4);
        chk("R8 starts after synchronized edge", count_o, 399);
        evt[5] = 1'b0;
        tick(10);
        chk("R8 keeps counting after input drops", count_o, 389);

        // R9 stop cascade level on event 7
        wr(3'd0, 0);
        wr(3'd6, 7);
        wr(3'd3, 32'h80);
        wr(3'd2, 1000);
        wr(3'd0, 1);
        tick(5);
        chk("R9 runs while stop low", {31'd0, enable_o}, 1);
        evt[7] = 1'b1;
        tick(4);
        chk("R9 stop clears enable", {31'd0, enable_o}, 0);
        chk("R9 stop clears active", {31'd0, active_o}, 0);
        v = count_o;
        tick(3);
        chk("R9 count frozen", count_o, v);

        // R10 stop at zero only
        wr(3'd0, 0);
        wr(3'd3, 32'h280);
        wr(3'd1, 8);
        wr(3'd2, 6);
        wr(3'd0, 3);
        tick(3);
        chk("R10 ignored at nonzero count", {31'd0, enable_o}, 1);
        chk("R10 count still running", count_o, 3);
        tick(4);
        chk("R10 disabled at zero", {31'd0, enable_o}, 0);
        chk("R10 active cleared", {31'd0, active_o}, 0);
        chk("R10 reloaded at zero", count_o, 8);
        evt[7] = 1'b0;

        // R12 interrupt disabled, status sticky
        wr(3'd0, 0);
        wr(3'd7, 1);
        wr(3'd3, 0);
        wr(3'd1, 4);
        wr(3'd2, 2);
        wr(3'd0, 1);
        hits = 0;
        for (int i = 0; i < 12; i++) begin
            tick(1);
            if (irq_o) hits++;
        end
        chk("R12 no pulse without interrupt enable", hits, 0);
        rd(3'd7, v); chk("R12 status set", v, 1);
        wr(3'd0, 0);
        wr(3'd7, 1);
        rd(3'd7, v); chk("R12 status cleared by write one", v, 0);
        wr(3'd0, 3);
        k = 0;
        do begin
            tick(1);
            k++;
        end while (!irq_o && k < 50);
        chk("R12 pulse seen", {31'd0, irq_o}, 1);
        tick(1);
        chk("R12 pulse one cycle", {31'd0, irq_o}, 0);

        // R11 count write while running
        wr(3'd0, 0);
        wr(3'd1, 1000);
        wr(3'd2, 800);
        wr(3'd0, 1);
        tick(3);
        chk("R11 running before write", count_o, 797);
        wr(3'd2, 100);
        chk("R11 loaded at write edge", count_o, 100);
        tick(1);
        chk("R11 continues from new value", count_o, 99);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule